// File: doc/BRIEF.md
# Timer Clock-Source Select Register

This block is a small control register that picks the clock source for two timers: a periodic wake-up timer and a watchdog. Software writes one byte through a simple write port. The register drives a one-bit source code for the periodic timer and a two-bit source code for the watchdog. It also produces a one-cycle restart pulse for each timer whenever that timer's selection bit actually changes, so the timer starts a fresh time-out period on the new clock.

The oscillator-based choices are only allowed while an oscillator-ready status input is high. While that status is low, the register refuses to set the oscillator-select bits. If the status drops while they are set, the register clears them by itself. A clear of that kind is a value change like any other and raises the matching restart pulse. The watchdog has a second select bit that routes it to an auxiliary clock. While that bit is set, it overrides the first watchdog bit, and it also hides changes of that bit from the watchdog restart.

All inputs are synchronous to `clk`. A write, or a forced clear, takes effect at the next rising edge. The readback, the source codes and the restart pulses all show the new state in the cycle that follows that edge.

Top module: `tmr_clksel_reg`

## Requirements
- R1: While `rst_n` is low, and after it is released, all select bits are 0, `rd_data` is 0, `pit_src` is 0, `wdg_src` is 00, and neither restart pulse is high until a value changes.
- R2: The register layout is as follows. Bit 0 is the primary watchdog select, bit 1 is the periodic-timer select and bit 2 is the watchdog auxiliary select. Bits 7:3 always read 0, and writes to them have no effect. `rd_data` shows the register one cycle after the write edge.
- R3: `pit_src` equals register bit 1. The value 0 selects the internal RC clock and 1 selects the oscillator clock.
- R4: `wdg_src` is 10 (auxiliary clock) when bit 2 is 1. Otherwise it is 01 (oscillator) when bit 0 is 1, and 00 (internal RC) when bit 0 is 0. The code 11 never appears.
- R5: A write with `osc_ok` low leaves bits 1 and 0 at 0, whatever the written data holds.
- R6: In any cycle where `osc_ok` is low, bits 1 and 0 are cleared at the next edge, with or without a write.
- R7: `pit_restart` is high for exactly the one cycle after any edge at which bit 1 changed value. The cause may be a write or a forced clear.
- R8: `wdg_restart` is high for the one cycle after an edge at which bit 0 changed value, provided bit 2 is 0 after that edge. If bit 2 is 1, a change of bit 0 gives no pulse.
- R9: A write that leaves a bit's value unchanged gives no pulse for it. A change of bit 2 alone never gives a pulse.
- R10: Bit 2 is not gated by `osc_ok`. It can be set, and it holds its value, while `osc_ok` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data byte |
| osc_ok | input | 1 | Oscillator qualified and running |
| rd_data | output | 8 | Register readback |
| pit_src | output | 1 | Periodic-timer clock source code |
| wdg_src | output | 2 | Watchdog clock source code |
| pit_restart | output | 1 | Periodic-timer restart pulse |
| wdg_restart | output | 1 | Watchdog restart pulse |

## Verification
The bench targets the masking of bit 0 by bit 2. A design that used the old value of bit 2, rather than the new one, would pulse, or stay silent, on the cycle where both bits change together. It also drives `osc_ok` low with no write and checks that a forced clear raises the same restart pulses as a software write. A design that only compared old and new values on writes would miss those pulses. Writes of unchanged values and writes of 1s while the oscillator is not ready make sure that no spurious pulse appears and that the gated bits are not set. A behavioural model steps through every register state crossed with every write value and status level. Any error in the source encoding or in the bit-2 gating therefore shows up at once.

// File: rtl/tmr_clksel_reg.sv
module tmr_clksel_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       osc_ok,
  output logic [7:0] rd_data,
  output logic       pit_src,
  output logic [1:0] wdg_src,
  output logic       pit_restart,
  output logic       wdg_restart
);
  logic pit_q, wsel0_q, wsel1_q;
  logic pit_d, wsel0_d, wsel1_d;
  logic pit_rs_q, wdg_rs_q;

  assign pit_d   = (wr_en ? wr_data[1] : pit_q)   & osc_ok;
  assign wsel0_d = (wr_en ? wr_data[0] : wsel0_q) & osc_ok;
  assign wsel1_d =  wr_en ? wr_data[2] : wsel1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pit_q    <= 1'b0;
      wsel0_q  <= 1'b0;
      wsel1_q  <= 1'b0;
      pit_rs_q <= 1'b0;
      wdg_rs_q <= 1'b0;
    end else begin
      pit_q    <= pit_d;
      wsel0_q  <= wsel0_d;
      wsel1_q  <= wsel1_d;
      pit_rs_q <= pit_d ^ pit_q;
      wdg_rs_q <= (wsel0_d ^ wsel0_q) & ~wsel1_d;
    end
  end

  assign rd_data     = {5'b0, wsel1_q, pit_q, wsel0_q};
  assign pit_src     = pit_q;
  assign wdg_src     = wsel1_q ? 2'b10 : {1'b0, wsel0_q};
  assign pit_restart = pit_rs_q;
  assign wdg_restart = wdg_rs_q;
endmodule

module tmr_clksel_reg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic       osc_ok,
  input logic [7:0] rd_data,
  input logic       pit_src,
  input logic [1:0] wdg_src,
  input logic       pit_restart,
  input logic       wdg_restart
);
  assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[7:3] == 5'b0);

  assert_no_code11_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wdg_src != 2'b11);

  assert_gated_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !osc_ok) |=> (rd_data[1:0] == 2'b00));

  assert_forced_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_ok |=> (!pit_src && rd_data[0] == 1'b0));

  assert_pit_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pit_restart == (rd_data[1] != $past(rd_data[1])));

  assert_wdg_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wdg_restart == ((rd_data[0] != $past(rd_data[0])) && !rd_data[2]));

  assert_aux_ungated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[2]) |=> rd_data[2]);
endmodule

bind tmr_clksel_reg tmr_clksel_reg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .osc_ok(osc_ok),
  .rd_data(rd_data), .pit_src(pit_src), .wdg_src(wdg_src),
  .pit_restart(pit_restart), .wdg_restart(wdg_restart)
);

// File: tb/tmr_clksel_reg_tb.sv
module tmr_clksel_reg_tb;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       osc_ok = 1'b0;
  logic [7:0] rd_data;
  logic       pit_src;
  logic [1:0] wdg_src;
  logic       pit_restart;
  logic       wdg_restart;

  int total = 0;
  int bad = 0;
  int m_pit = 0, m_w0 = 0, m_w1 = 0, e_pr = 0, e_wr = 0;

  always #(PERIOD/2) clk = ~clk;

  tmr_clksel_reg u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .osc_ok(osc_ok),
    .rd_data(rd_data), .pit_src(pit_src), .wdg_src(wdg_src),
    .pit_restart(pit_restart), .wdg_restart(wdg_restart)
  );

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    int ws;
    ws = m_w1 ? 2 : m_w0;
    cmp(tag, "rd_data", int'(rd_data), m_w1 * 4 + m_pit * 2 + m_w0);
    cmp(tag, "pit_src", int'(pit_src), m_pit);
    cmp(tag, "wdg_src", int'(wdg_src), ws);
    cmp(tag, "pit_restart", int'(pit_restart), e_pr);
    cmp(tag, "wdg_restart", int'(wdg_restart), e_wr);
  endtask

  task automatic step(input bit we, input logic [7:0] d, input bit ok, input string tag);
    int np, n0, n1;
    @(negedge clk);
    wr_en = we; wr_data = d; osc_ok = ok;
    if (we) begin
      np = d[1] & ok; n0 = d[0] & ok; n1 = d[2];
    end else begin
      np = m_pit & ok; n0 = m_w0 & ok; n1 = m_w1;
    end
    e_pr = (np != m_pit) ? 1 : 0;
    e_wr = ((n0 != m_w0) && n1 == 0) ? 1 : 0;
    m_pit = np; m_w0 = n0; m_w1 = n1;
    @(posedge clk);
    #1;
    check_all(tag);
  endtask

  initial begin
    #(PERIOD * 100000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    step(0, 8'h00, 1, "R1");

    step(1, 8'hFB, 0, "R5");
    step(1, 8'h03, 0, "R5");
    step(1, 8'hF8, 1, "R2");
    step(1, 8'h03, 1, "R7");
    step(1, 8'h03, 1, "R9");
    step(0, 8'h00, 1, "R9");
    step(0, 8'h00, 0, "R6");
    step(1, 8'h07, 0, "R10");
    step(0, 8'h00, 0, "R10");
    step(1, 8'h07, 1, "R8");
    step(1, 8'h06, 1, "R8");
    step(1, 8'h01, 1, "R8");
    step(1, 8'h04, 1, "R8");
    step(1, 8'h05, 1, "R4");
    step(1, 8'h01, 1, "R4");
    step(1, 8'h00, 1, "R4");
    step(1, 8'h02, 1, "R3");
    step(1, 8'h00, 1, "R3");

    for (int s = 0; s < 8; s++)
      for (int w = 0; w < 10; w++)
        for (int ok = 0; ok < 2; ok++) begin
          step(1, 8'(s), 1, "R2");
          if (w < 8) step(1, 8'(w) | 8'hA8, ok[0], "R2");
          else       step(0, 8'h00, ok[0], "R6");
        end

    for (int i = 0; i < 2000; i++)
      step(1'($urandom_range(0, 1)), 8'($urandom), ($urandom_range(0, 3) != 0), "R8");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule